// File: doc/BRIEF.md
# Nibble-Wide Accumulator Processor Core

A compact 4-bit processor intended as a control sequencer inside a larger device. Two working registers, A and B, hold 4-bit values. Each 8-bit instruction comes from a 16-entry program store. Its upper nibble picks one of sixteen operations, and its lower nibble serves as a store address or a jump target. The core retires one instruction per clock. The operations cover arithmetic, bitwise logic, a rotate through carry, loads from a separate 16-entry data store, a LIFO stack shared by register saves and subroutine links, and a 4-bit input and output port. Zero, sign and carry flags follow the results.

The program and data stores are filled through a load port. While the load enable is high, the core executes nothing and its program counter holds. After reset, a host keeps the load enable high, writes both stores, and then drops it. The core runs until it meets a halt instruction, and only a reset restarts it.

Top module: `nib_cpu`

## Requirements
- R1: A synchronous active-high reset clears A, B, the program counter, the flags, the output port and the halt indicator, and sets the stack pointer to 14.
- R2: While `ld_en` is high, no instruction executes and the program counter holds. Each cycle, `ld_data` is written at `ld_addr` into the program store (`ld_sel`=0) or into the data store (`ld_sel`=1, which keeps bits 3:0 only).
- R3: Instruction bits 7:4 are the opcode, in this order: 0 ADD, 1 SUB, 2 XCHG, 3 MOV, 4 RCR, 5 IN, 6 OUT, 7 AND, 8 TEST, 9 OR, 10 XOR, 11 PUSH, 12 POP, 13 CALL, 14 RET, 15 HLT. Bits 3:0 are the operand address or target. One instruction executes per clock, and the program counter wraps from 15 to 0.
- R4: ADD sets A to A+B and sets carry to the carry out. SUB sets A to A-B and sets carry when A<B (a borrow). Both set zero when the new A is 0 and set sign to bit 3 of the new A.
- R5: AND sets A to A&B. XOR sets A to A^mem. OR sets B to B|mem. TEST computes B&mem and leaves B unchanged. All four set zero and sign from their result and leave carry unchanged.
- R6: XCHG swaps A and B and sets zero and sign from the new A.
- R7: RCR shifts B right by one, moves the old carry into bit 3 and moves the old bit 0 into carry. Zero and sign follow the new B.
- R8: MOV loads A from the data store at the instruction's low nibble without touching the flags. The memory operand of XOR, OR and TEST is read from the same address.
- R9: IN copies `in_port` into A. OUT copies A to `out_port`, which holds its value until the next OUT or reset.
- R10: PUSH decrements the stack pointer and then writes B at the new location. POP loads B from the current location and then increments the pointer.
- R11: CALL pushes the address of the next instruction and jumps to the low nibble. RET pops the saved address into the program counter.
- R12: HLT raises `halted`. From then on, no instruction executes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Store write enable; stalls execution while high |
| ld_sel | input | 1 | 0 selects the program store, 1 the data store |
| ld_addr | input | 4 | Store write address |
| ld_data | input | 8 | Store write word |
| in_port | input | 4 | Value read by IN |
| out_port | output | 4 | Registered value written by OUT |
| flags | output | 3 | Registered flags: bit 2 zero, bit 1 sign, bit 0 carry |
| halted | output | 1 | Registered halt indicator |

## Verification
Each instruction's effect on `out_port`, `flags` and `halted` is due at the first rising edge after that instruction is fetched. An instruction fetched in the cycle after `ld_en` falls therefore shows its result one edge later. The result of the n-th instruction after release appears after n edges, and a stalled cycle adds exactly one edge. The bench drives inputs and samples outputs only on falling edges. Its behavioural model steps on the same rising edges, so the model and the ports are compared in every cycle. The directed checks count falling edges from the release of `ld_en` to reach the cycle at which each expected value is due.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_XCHG = 4'd2,
    OP_MOV  = 4'd3,
    OP_RCR  = 4'd4,
    OP_IN   = 4'd5,
    OP_OUT  = 4'd6,
    OP_AND  = 4'd7,
    OP_TEST = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_PUSH = 4'd11,
    OP_POP  = 4'd12,
    OP_CALL = 4'd13,
    OP_RET  = 4'd14,
    OP_HLT  = 4'd15
  } opcode_e;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
  } flags_t;

endpackage

// File: rtl/nib_regstore.sv
module nib_regstore #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read: distributed RAM keeps single-cycle execution
  assign rdata = mem[raddr];

endmodule

// File: rtl/nib_stack.sv
module nib_stack #(
  parameter int WORD_W  = 4,
  parameter int PTR_W   = 4,
  parameter int SP_INIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] top_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  sp;
  logic [PTR_W-1:0]  sp_dec;

  assign sp_dec = sp - 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       sp <= PTR_W'(SP_INIT);
    else if (push) sp <= sp_dec;
    else if (pop)  sp <= sp + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push && !rst) mem[sp_dec] <= wr_data;
  end

  assign top_data = mem[sp];

  AST_PUSH_LAND_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    push |=> top_data == $past(wr_data)); // R10

endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_cpu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] mem_op,
  input  logic [DATA_W-1:0] ext_in,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              wr_a,
  output logic              wr_b,
  output logic              set_zs,
  output logic              set_c
);
  logic [DATA_W:0] sum;

  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    res    = '0;
    cout   = cin;
    wr_a   = 1'b0;
    wr_b   = 1'b0;
    set_zs = 1'b0;
    set_c  = 1'b0;
    unique case (op)
      OP_ADD:  begin res = sum[DATA_W-1:0]; cout = sum[DATA_W];
                     wr_a = 1'b1; set_zs = 1'b1; set_c = 1'b1; end
      OP_SUB:  begin res = a - b; cout = (a < b);
                     wr_a = 1'b1; set_zs = 1'b1; set_c = 1'b1; end
      OP_XCHG: begin res = b; wr_a = 1'b1; set_zs = 1'b1; end
      OP_MOV:  begin res = mem_op; wr_a = 1'b1; end
      OP_RCR:  begin res = {cin, b[DATA_W-1:1]}; cout = b[0];
                     wr_b = 1'b1; set_zs = 1'b1; set_c = 1'b1; end
      OP_IN:   begin res = ext_in; wr_a = 1'b1; end
      OP_AND:  begin res = a & b; wr_a = 1'b1; set_zs = 1'b1; end
      OP_TEST: begin res = b & mem_op; set_zs = 1'b1; end
      OP_OR:   begin res = b | mem_op; wr_b = 1'b1; set_zs = 1'b1; end
      OP_XOR:  begin res = a ^ mem_op; wr_a = 1'b1; set_zs = 1'b1; end
      default: begin res = '0; end
    endcase
  end

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_cpu_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int SP_RESET = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_en,
  input  logic                      ld_sel,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [OPC_W+ADDR_W-1:0]   ld_data,
  input  logic [DATA_W-1:0]         in_port,
  output logic [DATA_W-1:0]         out_port,
  output logic [2:0]                flags,
  output logic                      halted
);
  localparam int INSTR_W = OPC_W + ADDR_W;
  localparam int STK_W   = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;

  logic [ADDR_W-1:0]  pc_q, pc_next, pc_inc;
  logic [DATA_W-1:0]  a_q, b_q, out_q;
  flags_t             flg_q;
  logic               halted_q;
  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  mem_op;
  logic [ADDR_W-1:0]  imm;
  opcode_e            op;
  logic               exec;
  logic [STK_W-1:0]   stk_wr, stk_top;
  logic               push, pop;
  logic [DATA_W-1:0]  res;
  logic               cout, wr_a, wr_b, set_zs, set_c;

  nib_regstore #(.WORD_W(INSTR_W), .ADDR_W(ADDR_W)) u_prog (
    .clk(clk), .we(ld_en && !ld_sel), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc_q), .rdata(instr));

  nib_regstore #(.WORD_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .we(ld_en && ld_sel), .waddr(ld_addr),
    .wdata(ld_data[DATA_W-1:0]), .raddr(imm), .rdata(mem_op));

  assign op     = opcode_e'(instr[INSTR_W-1 -: OPC_W]);
  assign imm    = instr[ADDR_W-1:0];
  assign exec   = !ld_en && !halted_q;
  assign pc_inc = pc_q + 1'b1;

  assign push   = exec && (op == OP_PUSH || op == OP_CALL);
  assign pop    = exec && (op == OP_POP  || op == OP_RET);
  assign stk_wr = (op == OP_CALL) ? STK_W'(pc_inc) : STK_W'(b_q);

  nib_stack #(.WORD_W(STK_W), .PTR_W(ADDR_W), .SP_INIT(SP_RESET)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_data(stk_wr), .top_data(stk_top));

  nib_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(a_q), .b(b_q), .mem_op(mem_op), .ext_in(in_port),
    .cin(flg_q.c), .res(res), .cout(cout), .wr_a(wr_a), .wr_b(wr_b),
    .set_zs(set_zs), .set_c(set_c));

  always_comb begin
    unique case (op)
      OP_CALL: pc_next = imm;
      OP_RET:  pc_next = stk_top[ADDR_W-1:0];
      OP_HLT:  pc_next = pc_q;
      default: pc_next = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      flg_q    <= '0;
      out_q    <= '0;
      halted_q <= 1'b0;
    end else if (exec) begin
      if (wr_a)           a_q <= res;
      if (wr_b)           b_q <= res;
      if (op == OP_XCHG)  b_q <= a_q;
      if (op == OP_POP)   b_q <= stk_top[DATA_W-1:0];
      if (set_zs) begin
        flg_q.z <= (res == '0);
        flg_q.s <= res[DATA_W-1];
      end
      if (set_c)          flg_q.c  <= cout;
      if (op == OP_OUT)   out_q    <= a_q;
      if (op == OP_HLT)   halted_q <= 1'b1;
      pc_q <= pc_next;
    end
  end

  assign out_port = out_q;
  assign flags    = flg_q;
  assign halted   = halted_q;

  AST_LOAD_STALLS_PC: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> $stable(pc_q)); // R2
  AST_PC_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (exec && pc_q == '1 && op != OP_CALL && op != OP_RET && op != OP_HLT) |=> pc_q == '0); // R3
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(exec && op == OP_OUT) |=> $stable(out_q)); // R9
  AST_CALL_JUMPS: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_CALL) |=> pc_q == $past(imm)); // R11
  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q); // R12

endmodule

// File: tb/nib_cpu_bench.sv
`timescale 1ns/1ps
module nib_cpu_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b1;
  logic       ld_sel = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] in_port = '0;
  logic [3:0] out_port;
  logic [2:0] flags;
  logic       halted;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nib_cpu u_nib_cpu (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .in_port(in_port), .out_port(out_port),
    .flags(flags), .halted(halted));

  // behavioural reference model
  int m_prog [16];
  int m_dat  [16];
  int m_stk  [16];
  int m_a, m_b, m_pc, m_sp, m_z, m_s, m_c, m_out, m_hlt;
  string m_tag = "R1";

  function automatic string tag_of(int opc);
    case (opc)
      0, 1:          return "R4";
      7, 8, 9, 10:   return "R5";
      2:             return "R6";
      4:             return "R7";
      3:             return "R8";
      5, 6:          return "R9";
      11, 12:        return "R10";
      13, 14:        return "R11";
      default:       return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_a = 0; m_b = 0; m_pc = 0; m_sp = 14;
      m_z = 0; m_s = 0; m_c = 0; m_out = 0; m_hlt = 0; m_tag = "R1";
    end else if (ld_en) begin
      if (ld_sel) m_dat[ld_addr] = ld_data & 15;
      else        m_prog[ld_addr] = ld_data;
      m_tag = "R2";
    end else if (m_hlt == 0) begin
      int opc, arg, mv, r, nxt;
      opc = m_prog[m_pc] >> 4;
      arg = m_prog[m_pc] & 15;
      mv  = m_dat[arg];
      nxt = (m_pc + 1) % 16;
      m_tag = tag_of(opc);
      case (opc)
        0: begin r = m_a + m_b; m_c = r / 16; m_a = r % 16; m_z = (m_a == 0); m_s = m_a / 8; end
        1: begin m_c = (m_a < m_b); m_a = (m_a - m_b + 16) % 16; m_z = (m_a == 0); m_s = m_a / 8; end
        2: begin r = m_a; m_a = m_b; m_b = r; m_z = (m_a == 0); m_s = m_a / 8; end
        3: m_a = mv;
        4: begin r = m_b % 2; m_b = m_c * 8 + m_b / 2; m_c = r; m_z = (m_b == 0); m_s = m_b / 8; end
        5: m_a = in_port;
        6: m_out = m_a;
        7: begin m_a = m_a & m_b; m_z = (m_a == 0); m_s = m_a / 8; end
        8: begin r = m_b & mv; m_z = (r == 0); m_s = r / 8; end
        9: begin m_b = m_b | mv; m_z = (m_b == 0); m_s = m_b / 8; end
        10: begin m_a = m_a ^ mv; m_z = (m_a == 0); m_s = m_a / 8; end
        11: begin m_sp = (m_sp + 15) % 16; m_stk[m_sp] = m_b; end
        12: begin m_b = m_stk[m_sp]; m_sp = (m_sp + 1) % 16; end
        13: begin m_sp = (m_sp + 15) % 16; m_stk[m_sp] = nxt; nxt = arg; end
        14: begin nxt = m_stk[m_sp]; m_sp = (m_sp + 1) % 16; end
        default: begin m_hlt = 1; nxt = m_pc; end
      endcase
      m_pc = nxt;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(m_tag, "out_port", out_port, m_out);
      chk(m_tag, "flags", flags, m_z * 4 + m_s * 2 + m_c);
      chk(m_tag, "halted", halted, m_hlt);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld_en = 1'b1; ld_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input bit sel, input int addr, input int data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = addr[3:0]; ld_data = data[7:0];
  endtask

  task automatic run();
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", "out_port after reset", out_port, 0);
    chk("R1", "flags after reset", flags, 0);
    chk("R1", "halted after reset", halted, 0);

    // program 1: arithmetic, logic, rotate, memory, stack, halt
    load(1, 0, 8'hA5); load(1, 1, 8'h03); load(1, 2, 8'h0C);
    begin
      int p1 [16] = '{8'h50, 8'h20, 8'h30, 8'h00, 8'h60, 8'h10, 8'h70, 8'hA1,
                      8'h60, 8'h41, 8'hB0, 8'h92, 8'hC0, 8'h20, 8'h60, 8'hF0};
      for (int i = 0; i < 16; i++) load(0, i, p1[i]);
    end
    in_port = 4'd9;
    wait_n(3);
    chk("R2", "out_port during load", out_port, 0);
    run();
    wait_n(4);
    chk("R4", "flags after ADD", flags, 3'b010);
    wait_n(1);
    chk("R4", "out_port after ADD", out_port, 14);
    wait_n(4);
    chk("R8", "out_port after AND/XOR mem (R5)", out_port, 2);
    wait_n(1);
    chk("R7", "flags after RCR", flags, 3'b001);
    wait_n(5);
    chk("R10", "out_port after PUSH/OR/POP", out_port, 4);
    wait_n(1);
    chk("R12", "halted after HLT", halted, 1);
    wait_n(5);
    chk("R12", "halted stays", halted, 1);
    chk("R12", "out_port frozen", out_port, 4);

    // program 2: subroutine link
    do_reset();
    @(negedge clk);
    chk("R12", "halted cleared by reset", halted, 0);
    load(1, 4, 8'h37);
    begin
      int p2 [8] = '{8'hD5, 8'h50, 8'h60, 8'hF0, 8'h00, 8'h34, 8'h60, 8'hE0};
      for (int i = 0; i < 8; i++) load(0, i, p2[i]);
    end
    in_port = 4'd3;
    run();
    wait_n(3);
    chk("R11", "out_port inside subroutine", out_port, 7);
    wait_n(3);
    chk("R11", "out_port after RET", out_port, 3);
    wait_n(1);
    chk("R12", "halted after return path", halted, 1);

    // program 3: stall mid-run and program counter wrap
    do_reset();
    load(0, 0, 8'h50); load(0, 1, 8'h60);
    for (int i = 2; i < 16; i++) load(0, i, 8'h80);
    in_port = 4'd6;
    run();
    wait_n(2);
    chk("R9", "out_port after IN/OUT", out_port, 6);
    ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 4'd5; ld_data = 8'h00;
    wait_n(3);
    chk("R2", "out_port during stall", out_port, 6);
    ld_en = 1'b0; in_port = 4'd11;
    wait_n(16);
    chk("R3", "out_port after wrap", out_port, 11);
    chk("R5", "TEST left B at zero flags", flags, 3'b100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule